// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations for 32-bit virtual addresses and 4 KB pages. A lookup gives a virtual address, an address-space tag, an access kind and a privilege level. One cycle later the block answers with exactly one of three outcomes. A hit carries the physical address. A miss tells an external page-table walker to fetch the translation. A protection fault means the entry matched but its permission bits forbid the access.

Each entry holds the virtual page number, the physical frame number, the address-space tag and three permission bits. The permission bits mark a page as write-protected, as not executable, or as usable only by the kernel. Each entry also holds an accessed flag and a modified flag. A hit reports the values these flags had before the access and then updates them, so the walker can tell when a flag must be written back. Because entries are tagged, a context switch does not have to empty the cache. Software can still flush every entry, or only the entries of one address space. After a miss, the walker installs the translation through the refill port.

Top module: `tlb_asid_xlate`

## Requirements
- R1: After reset no entry is valid, the response outputs are all zero, and any lookup misses.
- R2: On a hit, rsp_paddr equals the stored 20-bit frame number in bits 31:12, concatenated with bits 11:0 of the request address unchanged. The page number is bits 31:12 of lk_vaddr.
- R3: An entry matches only when it is valid and both its page number and its address-space tag equal those of the request. A matching page number under a different tag is a miss.
- R4: An accepted lookup gets a response in the next cycle, with rsp_valid high and exactly one of rsp_hit, rsp_miss and rsp_fault high. Without an accepted lookup, rsp_valid, rsp_hit, rsp_miss and rsp_fault stay low.
- R5: A matching entry raises rsp_fault instead of rsp_hit in three cases: a write (lk_acc=1) to a write-protected page, a fetch (lk_acc=2) from a no-execute page, or a user access (lk_user=1) to a kernel-only page. Code 0 and code 3 are reads.
- R6: On a hit, rsp_was_accessed shows the entry's accessed flag as it was before the access, and the hit then sets the flag. On a miss or fault, rsp_paddr, rsp_was_accessed and rsp_was_dirty are 0.
- R7: A write hit sets the entry's modified flag, which the next hit reports on rsp_was_dirty. A faulting access changes neither flag.
- R8: A refill installs a valid entry with both flags clear. It goes into the lowest-numbered invalid entry when one exists.
- R9: When every entry is valid, a refill replaces the entry at a rotating pointer. The pointer starts at 0 after reset, advances by one after each such replacement, wraps from 15 to 0, and is not changed by a flush.
- R10: A flush-all clears the valid bit of every entry.
- R11: A flush by address space clears only the entries whose tag equals fl_asid. All other entries keep hitting.
- R12: Requests in the same cycle are served in this order: flush first, then refill, then lookup. A request that loses is dropped, and a dropped lookup gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_asid | input | 8 | Address-space tag of the lookup |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation hit |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Match denied by a permission bit |
| rsp_paddr | output | 32 | Physical address on a hit, otherwise 0 |
| rsp_was_accessed | output | 1 | Accessed flag of the hit entry before this access |
| rsp_was_dirty | output | 1 | Modified flag of the hit entry before this access |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Page number to install |
| rf_asid | input | 8 | Address-space tag to install |
| rf_pfn | input | 20 | Frame number to install |
| rf_ro | input | 1 | Write-protected permission |
| rf_nx | input | 1 | No-execute permission |
| rf_kern | input | 1 | Kernel-only permission |
| fl_all | input | 1 | Invalidate every entry |
| fl_asid_valid | input | 1 | Invalidate the entries of one address space |
| fl_asid | input | 8 | Address space to invalidate |

## Verification
The assertions assume that no page number and tag pair is ever installed twice while an earlier copy is still valid. Under that assumption at most one entry can match, so the one-outcome and offset checks can rely on a single selected entry. The stimulus keeps to this by giving every refill a fresh page number from a counter, and by reusing a page number only after a flush or a rotating replacement has removed the old copy. Requests that overlap in one cycle are driven only on purpose, to exercise the priority order.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int ASID_W = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_e;

    typedef struct packed {
        logic ro;
        logic nx;
        logic kern;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_t             perm;
        logic              accessed;
        logic              dirty;
    } entry_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
        logic             accessed;
        logic             dirty;
    } hit_info_t;

    // Access is refused when any permission bit forbids it.
    function automatic logic perm_denied(perm_t p, acc_e a, logic user);
        return (p.ro && (a == ACC_WRITE)) ||
               (p.nx && (a == ACC_FETCH)) ||
               (p.kern && user);
    endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush_all,
    input  logic                    flush_asid_en,
    input  logic [ASID_W-1:0]       flush_asid,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  entry_t                  wr_entry,
    input  logic                    touch_en,
    input  logic [IDX_W-1:0]        touch_idx,
    input  logic                    touch_dirty,
    output entry_t [ENTRIES-1:0]    ents
);
    entry_t ent_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (flush_all) begin
                ent_q[g].valid <= 1'b0;
            end else if (flush_asid_en && (ent_q[g].asid == flush_asid)) begin
                ent_q[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q[g] <= wr_entry;
            end else if (touch_en && (touch_idx == IDX_W'(g))) begin
                ent_q[g].accessed <= 1'b1;
                if (touch_dirty) begin
                    ent_q[g].dirty <= 1'b1;
                end
            end
        end
        assign ents[g] = ent_q[g];
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  entry_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [ASID_W-1:0]    asid,
    output logic [ENTRIES-1:0]   hit_vec,
    output logic                 hit_any,
    output logic [IDX_W-1:0]     hit_idx,
    output hit_info_t            info
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].vpn == vpn) &&
                            (ents[g].asid == asid);
    end

    assign hit_any = |hit_vec;

    // OR-reduction select; at most one entry matches.
    always_comb begin
        hit_idx = '0;
        info    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
                info    = info | {ents[i].pfn, ents[i].perm,
                                  ents[i].accessed, ents[i].dirty};
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               fill,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             all_valid;

    assign all_valid = &valid_vec;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = all_valid ? ptr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill && all_valid) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_asid_xlate.sv
module tlb_asid_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              lk_user,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_was_accessed,
    output logic              rsp_was_dirty,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic              rf_ro,
    input  logic              rf_nx,
    input  logic              rf_kern,
    input  logic              fl_all,
    input  logic              fl_asid_valid,
    input  logic [ASID_W-1:0] fl_asid
);
    entry_t [ENTRIES-1:0] ents;
    logic   [ENTRIES-1:0] valid_vec;
    logic   [ENTRIES-1:0] hit_vec;
    logic                 hit_any;
    logic   [IDX_W-1:0]   hit_idx;
    logic   [IDX_W-1:0]   victim_idx;
    hit_info_t            info;
    entry_t               new_ent;
    acc_e                 acc;
    logic                 flush_any, do_refill, do_lookup, denied;
    logic                 good_hit, bad_hit;

    assign acc       = acc_e'(lk_acc);
    assign flush_any = fl_all | fl_asid_valid;
    assign do_refill = rf_valid & ~flush_any;
    assign do_lookup = lk_valid & ~rf_valid & ~flush_any;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign valid_vec[g] = ents[g].valid;
    end

    always_comb begin
        new_ent          = '0;
        new_ent.valid    = 1'b1;
        new_ent.asid     = rf_asid;
        new_ent.vpn      = rf_vpn;
        new_ent.pfn      = rf_pfn;
        new_ent.perm.ro  = rf_ro;
        new_ent.perm.nx  = rf_nx;
        new_ent.perm.kern = rf_kern;
    end

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ents),
        .vpn     (lk_vaddr[VA_W-1:OFF_W]),
        .asid    (lk_asid),
        .hit_vec (hit_vec),
        .hit_any (hit_any),
        .hit_idx (hit_idx),
        .info    (info)
    );

    assign denied   = perm_denied(info.perm, acc, lk_user);
    assign good_hit = do_lookup & hit_any & ~denied;
    assign bad_hit  = do_lookup & hit_any & denied;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .fill       (do_refill),
        .victim_idx (victim_idx)
    );

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk           (clk),
        .rst           (rst),
        .flush_all     (fl_all),
        .flush_asid_en (fl_asid_valid),
        .flush_asid    (fl_asid),
        .wr_en         (do_refill),
        .wr_idx        (victim_idx),
        .wr_entry      (new_ent),
        .touch_en      (good_hit),
        .touch_idx     (hit_idx),
        .touch_dirty   (acc == ACC_WRITE),
        .ents          (ents)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_miss         <= 1'b0;
            rsp_fault        <= 1'b0;
            rsp_paddr        <= '0;
            rsp_was_accessed <= 1'b0;
            rsp_was_dirty    <= 1'b0;
        end else begin
            rsp_valid        <= do_lookup;
            rsp_hit          <= good_hit;
            rsp_miss         <= do_lookup & ~hit_any;
            rsp_fault        <= bad_hit;
            rsp_paddr        <= good_hit ? {info.pfn, lk_vaddr[OFF_W-1:0]} : '0;
            rsp_was_accessed <= good_hit & info.accessed;
            rsp_was_dirty    <= good_hit & info.dirty;
        end
    end
endmodule

// File: rtl/tlb_asid_xlate_chk.sv
module tlb_asid_xlate_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [OFF_W-1:0]   lk_off,
    input logic               rf_valid,
    input logic               fl_all,
    input logic               fl_asid_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               rsp_was_accessed,
    input logic               rsp_was_dirty,
    input logic [ENTRIES-1:0] hit_vec
);
    logic accepted;
    assign accepted = lk_valid && !rf_valid && !fl_all && !fl_asid_valid;

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault} == 3'b000));

    p_lookup_answered_r4: assert property (@(posedge clk) disable iff (rst)
        accepted |=> rsp_valid);

    p_refill_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (rf_valid || fl_all || fl_asid_valid) |=> !rsp_valid);

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (!rsp_hit || (rsp_paddr[OFF_W-1:0] == $past(lk_off))));

    p_flush_then_miss_r10: assert property (@(posedge clk) disable iff (rst)
        fl_all ##1 accepted |=> rsp_miss);

    p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_no_data_on_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss || rsp_fault) |->
            (rsp_paddr == '0 && !rsp_was_accessed && !rsp_was_dirty));
endmodule

bind tlb_asid_xlate tlb_asid_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .lk_valid         (lk_valid),
    .lk_off           (lk_vaddr[11:0]),
    .rf_valid         (rf_valid),
    .fl_all           (fl_all),
    .fl_asid_valid    (fl_asid_valid),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit),
    .rsp_miss         (rsp_miss),
    .rsp_fault        (rsp_fault),
    .rsp_paddr        (rsp_paddr),
    .rsp_was_accessed (rsp_was_accessed),
    .rsp_was_dirty    (rsp_was_dirty),
    .hit_vec          (hit_vec)
);

// File: tb/tlb_asid_xlate_bench.sv
`timescale 1ns/1ps
module tlb_asid_xlate_bench;
    localparam int N = 16;
    localparam int HMAX = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_user = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        rsp_was_accessed, rsp_was_dirty;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_pfn = '0;
    logic        rf_ro = 1'b0, rf_nx = 1'b0, rf_kern = 1'b0;
    logic        fl_all = 1'b0, fl_asid_valid = 1'b0;
    logic [7:0]  fl_asid = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model
    bit        m_v [N];
    bit [19:0] m_vpn [N];
    bit [7:0]  m_asid [N];
    bit [19:0] m_pfn [N];
    bit        m_ro [N], m_nx [N], m_kern [N], m_a [N], m_d [N];
    int        m_ptr = 0;
    bit [19:0] h_vpn [HMAX];
    bit [7:0]  h_asid [HMAX];
    int        h_cnt = 0;
    int        seq = 0;

    always #5 clk = ~clk;

    tlb_asid_xlate u_tlb_asid_xlate (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_acc(lk_acc), .lk_user(lk_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_was_accessed(rsp_was_accessed), .rsp_was_dirty(rsp_was_dirty),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rf_pfn(rf_pfn), .rf_ro(rf_ro), .rf_nx(rf_nx), .rf_kern(rf_kern),
        .fl_all(fl_all), .fl_asid_valid(fl_asid_valid), .fl_asid(fl_asid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_fill(input bit [19:0] vpn, input bit [7:0] asid,
                              input bit [19:0] pfn, input bit ro, input bit nx,
                              input bit kern);
        int slot = -1;
        for (int j = 0; j < N; j++) if (!m_v[j] && slot < 0) slot = j;
        if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_v[slot] = 1; m_vpn[slot] = vpn; m_asid[slot] = asid; m_pfn[slot] = pfn;
        m_ro[slot] = ro; m_nx[slot] = nx; m_kern[slot] = kern;
        m_a[slot] = 0; m_d[slot] = 0;
        if (h_cnt < HMAX) begin
            h_vpn[h_cnt] = vpn; h_asid[h_cnt] = asid; h_cnt++;
        end
    endtask

    task automatic drive_refill(input bit [19:0] vpn, input bit [7:0] asid,
                                input bit ro, input bit nx, input bit kern,
                                output bit [19:0] pfn);
        seq++;
        pfn = 20'h80000 + 20'(seq * 'h321);
        rf_valid = 1; rf_vpn = vpn; rf_asid = asid; rf_pfn = pfn;
        rf_ro = ro; rf_nx = nx; rf_kern = kern;
    endtask

    task automatic refill(input bit [19:0] vpn, input bit [7:0] asid,
                          input bit ro, input bit nx, input bit kern);
        bit [19:0] pfn;
        @(negedge clk);
        drive_refill(vpn, asid, ro, nx, kern, pfn);
        @(negedge clk);
        rf_valid = 0;
        model_fill(vpn, asid, pfn, ro, nx, kern);
    endtask

    task automatic lookup(input bit [31:0] va, input bit [7:0] asid,
                          input bit [1:0] acc, input bit user, input string req);
        int idx = -1;
        bit deny;
        bit e_hit, e_miss, e_fault, e_a, e_d;
        bit [31:0] e_pa;
        for (int j = 0; j < N; j++)
            if (m_v[j] && m_vpn[j] == va[31:12] && m_asid[j] == asid) idx = j;
        e_hit = 0; e_miss = 0; e_fault = 0; e_a = 0; e_d = 0; e_pa = 0;
        if (idx < 0) e_miss = 1;
        else begin
            deny = (acc == 2'd1 && m_ro[idx]) || (acc == 2'd2 && m_nx[idx]) ||
                   (user && m_kern[idx]);
            if (deny) e_fault = 1;
            else begin
                e_hit = 1; e_pa = {m_pfn[idx], va[11:0]};
                e_a = m_a[idx]; e_d = m_d[idx];
                m_a[idx] = 1;
                if (acc == 2'd1) m_d[idx] = 1;
            end
        end
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_acc = acc; lk_user = user;
        @(negedge clk);
        lk_valid = 0;
        check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_was_accessed,
               rsp_was_dirty, rsp_paddr} == {1'b1, e_hit, e_miss, e_fault, e_a, e_d, e_pa},
              req, "response {valid,hit,miss,fault,acc,dirty,paddr}",
              {26'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_was_accessed,
               rsp_was_dirty, rsp_paddr},
              {26'd0, 1'b1, e_hit, e_miss, e_fault, e_a, e_d, e_pa});
    endtask

    task automatic sweep_history(input string req);
        for (int k = 0; k < h_cnt; k++)
            lookup({h_vpn[k], 12'h0A5 ^ 12'(k)}, h_asid[k], 2'd0, 1'b0, req);
    endtask

    task automatic flush_all_now();
        @(negedge clk);
        fl_all = 1;
        @(negedge clk);
        fl_all = 0;
        for (int j = 0; j < N; j++) m_v[j] = 0;
    endtask

    task automatic flush_asid_now(input bit [7:0] a);
        @(negedge clk);
        fl_asid_valid = 1; fl_asid = a;
        @(negedge clk);
        fl_asid_valid = 0;
        for (int j = 0; j < N; j++) if (m_asid[j] == a) m_v[j] = 0;
    endtask

    initial begin
        bit [19:0] pfn;
        for (int j = 0; j < N; j++) m_v[j] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: outputs quiet after reset, table empty
        check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr} == '0, "R1",
              "reset outputs", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, 64'd0);
        lookup(32'h12345678, 8'd0, 2'd0, 1'b0, "R1");

        // R8: fill the empty table, permission bits from the entry number
        for (int i = 0; i < N; i++)
            refill(20'h00100 + 20'(i * 37), 8'(i % 4), i[0], i[1], i[2]);

        // R2 R5 R6 R7: every permission set against every access kind and privilege
        for (int i = 0; i < N; i++)
            for (int u = 1; u >= 0; u--)
                for (int a = 0; a < 4; a++)
                    lookup({20'h00100 + 20'(i * 37), 12'((i * 97 + a * 13) & 'hFFF)},
                           8'(i % 4), 2'(a), u[0], "R2 R5 R6 R7");

        // R7: repeat write after write hits reports the modified flag
        lookup({20'h00100, 12'h004}, 8'd0, 2'd1, 1'b0, "R7");

        // R3: right page, wrong address space
        for (int i = 0; i < N; i++)
            lookup({20'h00100 + 20'(i * 37), 12'h010}, 8'(i % 4 + 4), 2'd0, 1'b0, "R3");

        // R9: table full, rotating replacement from entry 0
        for (int i = 0; i < 3; i++)
            refill(20'h20000 + 20'(i), 8'd9, 1'b0, 1'b0, 1'b0);
        sweep_history("R9");

        // R11: flush one address space, then R8 refill fills a hole
        flush_asid_now(8'd2);
        sweep_history("R11");
        refill(20'h30000, 8'd7, 1'b0, 1'b0, 1'b0);
        refill(20'h30001, 8'd7, 1'b0, 1'b0, 1'b0);
        sweep_history("R8");

        // R12: refill and lookup in one cycle
        @(negedge clk);
        drive_refill(20'h30002, 8'd7, 1'b0, 1'b0, 1'b0, pfn);
        lk_valid = 1; lk_vaddr = {20'h00100, 12'h0}; lk_asid = 8'd0; lk_acc = 2'd0;
        lk_user = 1'b0;
        @(negedge clk);
        rf_valid = 0; lk_valid = 0;
        model_fill(20'h30002, 8'd7, pfn, 1'b0, 1'b0, 1'b0);
        check(rsp_valid == 1'b0, "R12", "lookup beside refill answered",
              64'(rsp_valid), 64'd0);
        lookup({20'h30002, 12'h3FF}, 8'd7, 2'd0, 1'b0, "R12");

        // R12: flush beats refill in one cycle
        @(negedge clk);
        drive_refill(20'h30003, 8'd7, 1'b0, 1'b0, 1'b0, pfn);
        fl_all = 1;
        @(negedge clk);
        rf_valid = 0; fl_all = 0;
        for (int j = 0; j < N; j++) m_v[j] = 0;
        lookup({20'h30003, 12'h001}, 8'd7, 2'd0, 1'b0, "R12");

        // R10: everything gone after flush-all
        flush_all_now();
        sweep_history("R10");

        // R9: wrap of the rotating pointer across many replacements
        for (int i = 0; i < 36; i++)
            refill(20'h40000 + 20'(i), 8'(i % 3), 1'b0, 1'b0, 1'b0);
        sweep_history("R9");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule